// File: doc/BRIEF.md
# ARINC 429 Receive Label Filter and Word Queue

This block sits behind an ARINC 429 bit receiver. That receiver hands over complete 32-bit words that it has already checked. For each word, the block decides whether to keep it. The decision rests on two things: the word's 8-bit label, looked up in a 256-entry enable table, and an optional required value for ARINC bits 9 and 10. Words that pass are queued in a 32-deep by 32-bit first-in first-out store, and a host drains that store one word at a time.

The incoming word stream has a valid strobe and no ready. A serial line cannot be stalled, so the block never pushes back. When the queue is full, a new word replaces the newest stored word, and the 31 older words stay as they were.

The outgoing stream is valid/ready:
- `out_valid` is high whenever at least one word is stored.
- `out_data` shows the oldest word.
- A word is removed on a rising clock edge where `out_valid` and `out_ready` are both high.
- While the queue is empty, `out_data` reads zero, and `out_ready` has no effect.

The host can poll the empty and full levels directly. It can also use the single `rx_flag` pin, whose meaning is chosen by `flag_mode`.

Top module: `a429_rx_label_fifo`

## Requirements
- R1: After reset the queue is empty, `fifo_full` is 0, `out_valid` is 0, `out_data` is zero and every label-table entry is 0.
- R2: With `lbl_filt_en`=1, a word whose label (`in_word[7:0]`) has table entry 0 is discarded, and a word whose label entry is 1 is stored. A table entry is written with `lbl_wr_en`, `lbl_wr_addr`, `lbl_wr_val` and takes effect from the next clock.
- R3: With `bits_chk_en`=1, a word is stored only if `in_word[8]` (ARINC bit 9) equals `req_b9` and `in_word[9]` (ARINC bit 10) equals `req_b10`. This check combines with R2: both must pass.
- R4: With `lbl_filt_en`=0 and `bits_chk_en`=0, every word presented with `in_valid`=1 is stored.
- R5: Stored words leave in arrival order. `out_valid` is 1 exactly when the queue holds a word, and `out_data` shows the oldest one.
- R6: `fifo_full` is 1 exactly when 32 words are stored, and `fifo_empty` is 1 exactly when none are.
- R7: A kept word that arrives while the queue is full, with no removal in the same cycle, replaces the newest stored word. The older 31 words and the fill level are unchanged.
- R8: With the queue empty, `out_data` is zero, and asserting `out_ready` changes nothing: a later word is still returned correctly.
- R9: With `flag_mode`=0, `rx_flag` equals not-empty. With `flag_mode`=1, `rx_flag` equals full.
- R10: When the queue is full and a removal and a kept arrival occur in the same cycle, the oldest word leaves, the new word is appended at the back, and the queue stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Validated received word present this cycle |
| in_word | input | 32 | Received word: label in [7:0], ARINC bit 9 in [8], bit 10 in [9] |
| out_valid | output | 1 | Queue holds at least one word |
| out_ready | input | 1 | Host takes the oldest word |
| out_data | output | 32 | Oldest stored word, zero when empty |
| lbl_wr_en | input | 1 | Write one label-table entry |
| lbl_wr_addr | input | 8 | Label whose entry is written |
| lbl_wr_val | input | 1 | New entry value, 1 = accept label |
| lbl_filt_en | input | 1 | Apply label-table filtering |
| bits_chk_en | input | 1 | Apply bit 9/10 match |
| req_b9 | input | 1 | Required value of ARINC bit 9 |
| req_b10 | input | 1 | Required value of ARINC bit 10 |
| flag_mode | input | 1 | rx_flag meaning: 0 not-empty, 1 full |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue holds 32 words |
| rx_flag | output | 1 | Host attention flag per flag_mode |

## Verification
The assertions assume a few things about the inputs:
- The configuration pins stay steady around each word.
- `in_valid` carries a word that is already complete.
- No input is driven with X after reset.

The stimulus meets these assumptions by changing inputs only on the falling clock edge and by changing configuration only while no word is being presented. It also drives full-queue arrivals both with and without a removal in the same cycle, so that the overwrite rule and the exchange rule are each exercised at the 32-word boundary.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int WORD_W  = 32;
  localparam int LABEL_W = 8;
  localparam int B9_POS  = 8;
  localparam int B10_POS = 9;

  typedef struct packed {
    logic lbl_filt_en;
    logic bits_chk_en;
    logic req_b9;
    logic req_b10;
  } filt_cfg_t;

  function automatic logic [LABEL_W-1:0] label_of(input logic [WORD_W-1:0] w);
    return w[LABEL_W-1:0];
  endfunction
endpackage

// File: rtl/a429_label_table.sv
module a429_label_table #(
  parameter int AW = 8,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_val,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en) en_q[wr_addr] <= wr_val;
  end

  assign rd_hit = en_q[rd_addr];

  assert_tbl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q[$past(wr_addr)] == $past(wr_val)));
endmodule

// File: rtl/a429_word_filter.sv
module a429_word_filter
  import a429_rx_pkg::*;
(
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  filt_cfg_t         cfg,
  input  logic              lbl_hit,
  output logic              keep
);
  logic bits_ok, lbl_ok;

  always_comb begin
    bits_ok = (in_word[B9_POS] == cfg.req_b9) && (in_word[B10_POS] == cfg.req_b10);
    lbl_ok  = lbl_hit;
    keep    = in_valid
              && (!cfg.lbl_filt_en || lbl_ok)
              && (!cfg.bits_chk_en || bits_ok);
  end
endmodule

// File: rtl/a429_ovw_fifo.sv
module a429_ovw_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop_req,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [CW-1:0] count;
  logic do_pop, do_push, ovw;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty    = (count == '0);
    full     = (count == CW'(DEPTH));
    do_pop   = pop_req && !empty;
    ovw      = push && full && !do_pop;
    do_push  = push && !ovw;
    last_ptr = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;
    dout     = empty ? '0 : mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
    else if (ovw) mem[last_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop_req) |=> (full && $stable(rd_ptr) && $stable(wr_ptr)));
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> (empty && $stable(rd_ptr) && $stable(wr_ptr)));
  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (dout == '0));
  assert_full_exchange_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop_req) |=> full);
endmodule

// File: rtl/a429_rx_label_fifo.sv
module a429_rx_label_fifo
  import a429_rx_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  input  logic        lbl_wr_en,
  input  logic [7:0]  lbl_wr_addr,
  input  logic        lbl_wr_val,
  input  logic        lbl_filt_en,
  input  logic        bits_chk_en,
  input  logic        req_b9,
  input  logic        req_b10,
  input  logic        flag_mode,
  output logic        fifo_empty,
  output logic        fifo_full,
  output logic        rx_flag
);
  filt_cfg_t cfg;
  logic      lbl_hit, keep;

  assign cfg = '{lbl_filt_en: lbl_filt_en, bits_chk_en: bits_chk_en,
                 req_b9: req_b9, req_b10: req_b10};

  a429_label_table #(.AW(LABEL_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(lbl_wr_en), .wr_addr(lbl_wr_addr), .wr_val(lbl_wr_val),
    .rd_addr(label_of(in_word)), .rd_hit(lbl_hit)
  );

  a429_word_filter u_filt (
    .in_valid(in_valid), .in_word(in_word), .cfg(cfg),
    .lbl_hit(lbl_hit), .keep(keep)
  );

  a429_ovw_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(keep), .din(in_word),
    .pop_req(out_ready), .dout(out_data),
    .empty(fifo_empty), .full(fifo_full)
  );

  assign out_valid = !fifo_empty;
  assign rx_flag   = flag_mode ? fifo_full : !fifo_empty;

  assert_filter_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lbl_filt_en && !lbl_hit && fifo_empty && !out_ready) |=> fifo_empty);
  assert_flag_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !flag_mode) |-> out_valid);
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> (fifo_empty && !fifo_full));
endmodule

// File: tb/a429_rx_label_fifo_tb.sv
`timescale 1ns/1ps
module a429_rx_label_fifo_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, lbl_wr_en = 0, lbl_wr_val = 0;
  logic [31:0] in_word = '0;
  logic [7:0]  lbl_wr_addr = '0;
  logic lbl_filt_en = 0, bits_chk_en = 0, req_b9 = 0, req_b10 = 0, flag_mode = 0;
  logic out_valid, fifo_empty, fifo_full, rx_flag;
  logic [31:0] out_data;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  logic [255:0] tbl_m = '0;

  always #5 clk = ~clk;

  a429_rx_label_fifo u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit keep_m(input logic [31:0] w);
    return (!lbl_filt_en || tbl_m[w[7:0]]) &&
           (!bits_chk_en || (w[8] == req_b9 && w[9] == req_b10));
  endfunction

  task automatic wr_tbl(input logic [7:0] a, input logic v);
    lbl_wr_en = 1; lbl_wr_addr = a; lbl_wr_val = v;
    @(negedge clk);
    lbl_wr_en = 0;
    tbl_m[a] = v;
  endtask

  // driver: presents a word and records the expected queue contents
  task automatic send(input logic [31:0] w);
    in_valid = 1; in_word = w;
    if (keep_m(w)) begin
      if (exp_q.size() == 32) exp_q[31] = w;
      else exp_q.push_back(w);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor: pops one word and compares with the scoreboard
  task automatic take(input string req);
    logic [31:0] e;
    e = exp_q.pop_front();
    chk(out_valid == 1, req, {31'b0, out_valid}, 32'd1);
    chk(out_data == e, req, out_data, e);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) take(req);
    chk(out_valid == 0 && fifo_empty == 1, req, {30'b0, out_valid, fifo_empty}, 32'd1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(fifo_empty == 1, "R1", {31'b0, fifo_empty}, 1);
    chk(fifo_full == 0, "R1", {31'b0, fifo_full}, 0);
    chk(out_valid == 0, "R1", {31'b0, out_valid}, 0);
    chk(out_data == 0, "R1", out_data, 0);
    chk(rx_flag == 0, "R9", {31'b0, rx_flag}, 0);
    // R1 table cleared: label filter on drops everything
    lbl_filt_en = 1;
    send(32'h1234_5605);
    chk(fifo_empty == 1, "R1", {31'b0, fifo_empty}, 1);
    lbl_filt_en = 0;

    // R4 no filtering: everything stored, R5 order
    for (int i = 0; i < 5; i++) send(32'hA500_0000 + i * 32'h0101_0137);
    chk(rx_flag == 1, "R9", {31'b0, rx_flag}, 1);
    flag_mode = 1;
    @(negedge clk);
    chk(rx_flag == 0, "R9", {31'b0, rx_flag}, 0);
    flag_mode = 0;
    drain("R4");

    // R8 empty read has no effect
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_data == 0 && out_valid == 0, "R8", out_data, 0);
    send(32'hDEAD_BEEF);
    drain("R8");

    // R2 label table filtering
    wr_tbl(8'h05, 1); wr_tbl(8'hA7, 1); wr_tbl(8'hFF, 1); wr_tbl(8'h10, 1); wr_tbl(8'h10, 0);
    lbl_filt_en = 1;
    send(32'h0000_1105); send(32'h0000_2206); send(32'h0000_33A7);
    send(32'h0000_4410); send(32'h0000_55FF); send(32'h0000_6600);
    chk(exp_q.size() == 3, "R2", exp_q.size(), 3);
    drain("R2");

    // R3 bit 9/10 match combined with labels
    bits_chk_en = 1; req_b9 = 1; req_b10 = 0;
    send(32'h0000_0105); send(32'h0000_0205); send(32'h0000_0305);
    send(32'h0000_0005); send(32'h0000_0106); send(32'h0000_01A7);
    lbl_filt_en = 0; req_b9 = 0; req_b10 = 1;
    send(32'h0000_0233); send(32'h0000_0133);
    drain("R3");
    bits_chk_en = 0;

    // R6 fill, R7 overwrite
    for (int i = 0; i < 31; i++) send(32'h7000_0000 + i);
    chk(fifo_full == 0, "R6", {31'b0, fifo_full}, 0);
    send(32'h7000_001F);
    chk(fifo_full == 1, "R6", {31'b0, fifo_full}, 1);
    flag_mode = 1;
    @(negedge clk);
    chk(rx_flag == 1, "R9", {31'b0, rx_flag}, 1);
    send(32'hBBBB_0001); send(32'hBBBB_0002);
    chk(fifo_full == 1, "R7", {31'b0, fifo_full}, 1);
    chk(exp_q[31] == 32'hBBBB_0002, "R7", exp_q[31], 32'hBBBB_0002);

    // R10 exchange when full
    in_valid = 1; in_word = 32'hCCCC_0001; out_ready = 1;
    chk(out_data == exp_q[0], "R10", out_data, exp_q[0]);
    void'(exp_q.pop_front());
    exp_q.push_back(32'hCCCC_0001);
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    chk(fifo_full == 1, "R10", {31'b0, fifo_full}, 1);
    drain("R7");
    chk(rx_flag == 0, "R9", {31'b0, rx_flag}, 0);
    flag_mode = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule